// File: doc/BRIEF.md
# Parity-Protected Synchronous Word Store

This block is a clocked, single-port static word store with separate write and read data buses. A write on a rising clock edge saves a 32-bit word together with one extra even-parity bit that never appears at any port. A read on a rising clock edge returns the saved word, registers it on the read bus, and checks the saved parity. When the parity check fails, a sticky error flag rises and the failing address is recorded internally.

The read bus is tri-state. It is released to high impedance at once when chip enable drops. While chip enable is low, clock edges change nothing. A data-ready output tells a consumer that the read bus holds a freshly read, stable word. A test input lets a bench or a built-in self-test store a word with deliberately wrong parity. The number of words is set by one parameter, the address width. The default is 5 address bits, which gives 32 words.

Top module: `psram_core`

## Requirements
- R1: With chip enable high, write high and read low at a rising edge, the word on wdata is stored at addr. Other addresses are unchanged.
- R2: With chip enable high, read high and write low at a rising edge, the word stored at addr appears on rdata after that edge, and data_ready is 1 from that edge on.
- R3: With chip enable high and neither strobe asserted at an edge, rdata and data_ready keep their previous values.
- R4: With read and write both asserted at an edge, only the read takes place. Nothing is stored, the stored word at addr is driven on rdata, and data_ready is 0 after the edge.
- R5: Any edge that performs a write leaves data_ready at 0.
- R6: While chip enable is low, rdata_oe and data_ready are 0 and rdata is high impedance, with no clock needed. Edges in that state store nothing and do not change parity_err.
- R7: Each stored word carries a parity bit that makes the 33-bit total of ones even. When inject_perr is 1 on a write, that bit is stored inverted. A read of such a word sets parity_err to 1 after the edge, and rdata still returns the 32 data bits.
- R8: parity_err stays 1 until the recorded failing address is read again with correct parity. A failing read of another address moves the record to that address. A clean read of any address other than the recorded one leaves the flag set.
- R9: After reset, data_ready is 0, parity_err is 0 and the read register holds zero.
- R10: The address width parameter ADDR_W sets the depth to 2**ADDR_W words (default 5 bits, 32 words). Every address, including 0 and the top address, holds its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Asynchronous chip enable, active high |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| inject_perr | input | 1 | Test input: store inverted parity on a write |
| rdata | output | DATA_W | Tri-state read data |
| rdata_oe | output | 1 | 1 while the read bus is driven |
| data_ready | output | 1 | Read bus holds valid, freshly read data |
| parity_err | output | 1 | Sticky parity-error flag |

## Verification
The read word, data_ready and parity_err all come from registers that load on the edge where the strobe is sampled. They are due one edge after the inputs are driven, so the bench tags every expected item with the cycle in which it falls due. The bench compares each item 2 ns after that edge, well away from the falling edge at which inputs change. The release of the read bus and the drop of data_ready when chip enable goes low are combinational. They are checked 1 ns after chip enable falls, with no edge in between. A reference copy of the word contents and of the sticky error rule, built from the requirements, supplies every expected value.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_CLASH = 2'd3
  } op_e;

  function automatic op_e decode_op(input logic ce, input logic rd, input logic wr);
    op_e o;
    if (!ce)           o = OP_IDLE;
    else if (rd && wr) o = OP_CLASH;
    else if (rd)       o = OP_READ;
    else if (wr)       o = OP_WRITE;
    else               o = OP_IDLE;
    return o;
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned CELL_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CELL_W-1:0] wr_cell,
  output logic [CELL_W-1:0] rd_cell
);
  logic [CELL_W-1:0] cell_bus [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic              hit;
    logic [CELL_W-1:0] cell_q;

    assign hit = wr_stb && (addr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (hit) cell_q <= wr_cell;
    end

    assign cell_bus[g] = cell_q;
  end

  assign rd_cell = cell_bus[addr];
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CELL_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CELL_W-1:0] rd_cell,
  output logic [DATA_W-1:0] rd_word_q,
  output logic              ready_q,
  output logic              perr_q
);
  logic [DATA_W-1:0] rd_word_n;
  logic              ready_n;
  logic              perr_n;
  logic [ADDR_W-1:0] perr_addr_q, perr_addr_n;
  logic              step_en;
  logic              cell_ok;

  assign cell_ok = ~^rd_cell;
  assign step_en = (op != OP_IDLE);

  always_comb begin
    rd_word_n   = rd_word_q;
    ready_n     = ready_q;
    perr_n      = perr_q;
    perr_addr_n = perr_addr_q;
    unique case (op)
      OP_READ, OP_CLASH: begin
        rd_word_n = rd_cell[DATA_W-1:0];
        ready_n   = (op == OP_READ);
        if (!cell_ok) begin
          perr_n      = 1'b1;
          perr_addr_n = addr;
        end else if (perr_q && (addr == perr_addr_q)) begin
          perr_n = 1'b0;
        end
      end
      OP_WRITE: ready_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word_q   <= '0;
      ready_q     <= 1'b0;
      perr_q      <= 1'b0;
      perr_addr_q <= '0;
    end else if (step_en) begin
      rd_word_q   <= rd_word_n;
      ready_q     <= ready_n;
      perr_q      <= perr_n;
      perr_addr_q <= perr_addr_n;
    end
  end
endmodule

// File: rtl/psram_core.sv
module psram_core
  import psram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              inject_perr,
  output wire  [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              data_ready,
  output logic              parity_err
);
  localparam int unsigned CELL_W = DATA_W + 1;

  logic              rst_ns;
  op_e               op;
  logic              wr_stb;
  logic [CELL_W-1:0] wr_cell;
  logic [CELL_W-1:0] rd_cell;
  logic [DATA_W-1:0] rd_word_q;
  logic              ready_q;

  psram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ns)
  );

  assign op      = decode_op(chip_en, rd_en, wr_en);
  assign wr_stb  = (op == OP_WRITE);
  assign wr_cell = {(^wdata) ^ inject_perr, wdata};

  psram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .wr_stb  (wr_stb),
    .addr    (addr),
    .wr_cell (wr_cell),
    .rd_cell (rd_cell)
  );

  psram_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .op        (op),
    .addr      (addr),
    .rd_cell   (rd_cell),
    .rd_word_q (rd_word_q),
    .ready_q   (ready_q),
    .perr_q    (parity_err)
  );

  assign rdata_oe   = chip_en;
  assign data_ready = chip_en & ready_q;
  assign rdata      = chip_en ? rd_word_q : {DATA_W{1'bz}};
endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              rd_en,
  input logic              wr_en,
  input logic              data_ready,
  input logic              parity_err,
  input logic [DATA_W-1:0] rdata
);
  AST_READ_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && rd_en && !wr_en) |=> (data_ready || !chip_en)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !rd_en && !wr_en) |=> (!chip_en || $stable(rdata))); // R3

  AST_CLASH_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && rd_en && wr_en) |=> !data_ready); // R4

  AST_WRITE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && wr_en && !rd_en) |=> !data_ready); // R5

  AST_OFF_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> !data_ready); // R6

  AST_OFF_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(parity_err)); // R6

  AST_ERR_RISE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> $past(chip_en && rd_en)); // R7

  AST_ERR_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_err) |-> $past(chip_en && rd_en)); // R8
endmodule

bind psram_core psram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_ns),
  .chip_en    (chip_en),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .data_ready (data_ready),
  .parity_err (parity_err),
  .rdata      (rdata)
);

// File: tb/psram_core_test.sv
`timescale 1ns/1ps
module psram_core_test;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chip_en, rd_en, wr_en, inject_perr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  wire  [DW-1:0] rdata;
  logic          rdata_oe, data_ready, parity_err;

  always #5 clk = ~clk;

  psram_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .inject_perr(inject_perr), .rdata(rdata),
    .rdata_oe(rdata_oe), .data_ready(data_ready), .parity_err(parity_err)
  );

  typedef struct {
    int            due;
    bit            chk_data;
    logic [DW-1:0] exp_data;
    logic          exp_ready;
    logic          exp_err;
    string         tag;
  } item_t;

  item_t         sb_q[$];
  int            cyc = 0;
  int            checks = 0;
  int            failures = 0;
  bit            done = 0;

  logic [DW-1:0] m_mem [NW];
  bit            m_bad [NW];
  logic [DW-1:0] m_last = '0;
  logic          m_ready = 1'b0;
  logic          m_err = 1'b0;
  int            m_eaddr = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares due items 2 ns after each rising edge
  always @(posedge clk) begin
    cyc++;
    #2;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.chk_data) check({it.tag, " rdata"}, rdata, it.exp_data);
      check({it.tag, " data_ready"}, {31'b0, data_ready}, {31'b0, it.exp_ready});
      check({it.tag, " parity_err"}, {31'b0, parity_err}, {31'b0, it.exp_err});
    end
  end

  // driver: one operation per cycle, expected outcome pushed to the scoreboard
  task automatic step(input bit ce, input bit rd, input bit wr, input int a,
                      input logic [DW-1:0] d, input bit inj, input string tag);
    item_t it;
    @(negedge clk);
    chip_en = ce; rd_en = rd; wr_en = wr; addr = AW'(a); wdata = d; inject_perr = inj;
    if (ce && rd) begin
      m_last  = m_mem[a];
      m_ready = !wr;
      if (m_bad[a]) begin m_err = 1'b1; m_eaddr = a; end
      else if (m_err && a == m_eaddr) m_err = 1'b0;
    end else if (ce && wr) begin
      m_mem[a] = d; m_bad[a] = inj; m_ready = 1'b0;
    end
    it.due = cyc + 1;
    it.chk_data = ce;
    it.exp_data = m_last;
    it.exp_ready = ce ? m_ready : 1'b0;
    it.exp_err = m_err;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b1, 1'b0, 1'b0, 0, '0, 1'b0, tag);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; chip_en = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0; inject_perr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R9 reset state
    check("R9 rdata after reset", rdata, '0);
    check("R9 data_ready after reset", {31'b0, data_ready}, 32'd0);
    check("R9 parity_err after reset", {31'b0, parity_err}, 32'd0);

    // R1/R10: incrementing pattern across every address, then read back
    for (int i = 0; i < NW; i++)
      step(1, 0, 1, i, 32'hA500_0000 + i * 32'h0001_0203, 0, "R1 R5 write fill");
    for (int i = 0; i < NW; i++)
      step(1, 1, 0, i, '0, 0, "R2 R10 read fill");

    // R10: address 0 and the top address
    step(1, 0, 1, 0, 32'hFFFF_FFFF, 0, "R5 write addr0");
    step(1, 0, 1, NW - 1, 32'h8000_0001, 0, "R5 write top");
    step(1, 1, 0, NW - 1, '0, 0, "R10 read top");
    step(1, 1, 0, 0, '0, 0, "R10 read addr0");
    step(1, 1, 0, 1, '0, 0, "R1 neighbour unchanged");

    // R3: idle holds data and ready
    idle("R3 idle hold 1");
    idle("R3 idle hold 2");

    // R4: read and write together
    step(1, 1, 1, 4, 32'hDEAD_BEEF, 0, "R4 clash");
    step(1, 1, 0, 4, '0, 0, "R4 clash stored nothing");

    // R6: chip disabled
    @(negedge clk);
    chip_en = 1'b0;
    #1;
    check("R6 rdata_oe low", {31'b0, rdata_oe}, 32'd0);
    check("R6 data_ready low", {31'b0, data_ready}, 32'd0);
    step(0, 0, 1, 6, 32'h1234_5678, 0, "R6 write ignored");
    step(0, 1, 0, 6, '0, 0, "R6 read ignored");
    step(1, 1, 0, 6, '0, 0, "R6 word kept");

    // R7/R8: parity injection
    step(1, 0, 1, 3, 32'h0F0F_0F0F, 1, "R7 bad write 3");
    step(1, 1, 0, 3, '0, 0, "R7 bad read 3");
    step(1, 1, 0, 5, '0, 0, "R8 clean other keeps flag");
    step(1, 1, 0, 3, '0, 0, "R8 bad again keeps flag");
    step(1, 0, 1, 3, 32'h0F0F_0F0F, 0, "R8 rewrite 3 clean");
    step(1, 1, 0, 3, '0, 0, "R8 clean reread clears");
    step(1, 0, 1, 7, 32'h7777_0000, 1, "R7 bad write 7");
    step(1, 0, 1, 9, 32'h0000_9999, 1, "R7 bad write 9");
    step(1, 1, 0, 7, '0, 0, "R7 bad read 7");
    step(1, 1, 0, 9, '0, 0, "R8 bad read 9 moves record");
    step(1, 0, 1, 7, 32'h7777_0000, 0, "R8 rewrite 7 clean");
    step(1, 1, 0, 7, '0, 0, "R8 clean 7 not recorded keeps flag");
    step(1, 0, 1, 9, 32'h0000_9999, 0, "R8 rewrite 9 clean");
    step(1, 1, 0, 9, '0, 0, "R8 clean 9 clears");
    idle("R3 final idle");
    idle("R3 final idle");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    report();
  end
endmodule